// File: doc/BRIEF.md
# Divide-by-2.5 Clock Generator

This block takes one input clock and produces a slower clock at two fifths of its frequency, for example 4 MHz from 10 MHz. It is meant for boards where the input clock comes in on an ordinary I/O pin and cannot reach a frequency synthesizer. Only flip-flops and gates are used. The rising and the falling edges of the input clock are both used, so the output can change on any half-period of the input.

A two-pulse group lasts five input periods. A counter in the rising-edge domain steps through the five phases of the group. A mirror register in the falling-edge domain follows that counter. The first pulse of a group is a flop in the rising-edge domain. The second pulse is a flop in the falling-edge domain. Each output pulse is high for one input period and low for one and a half. The output is the OR of these two flops. The two flops are never high together, and on any input edge at most one of them changes, so the output net has no hazard. Because the pulses start on alternating edge polarities, any asymmetry in the input duty cycle shows up as jitter on the output.

The reset is asynchronous and active-low, and its release is synchronized to the input clock. The enable is sampled only at the start of a two-pulse group. This way a group that has begun always ends after a complete high phase.

Top module: `hdiv_clk_gen`

## Requirements
- R1: While `en` is held high, consecutive rising edges of `clk_div` are five input half-periods (2.5 input periods) apart.
- R2: Each `clk_div` pulse in normal running is high for exactly two input half-periods (one input period) and low for three, giving a 40% duty cycle.
- R3: `clk_div` is the OR of one flop clocked on the rising edge of `clk_in` and one flop clocked on its falling edge. The two are never high together. Within a group, the first pulse rises on a rising input edge and the second pulse rises on a falling input edge.
- R4: While `rst_n` is low, `clk_div` is low. Asserting `rst_n` forces a high output low in the same instant, without waiting for a clock edge, and clears the phase state.
- R5: After `rst_n` is released (changed between two rising edges of `clk_in`) with `en` high, the first rising edge of `clk_div` occurs on the third rising edge of `clk_in` after the release.
- R6: `en` is sampled only on the rising input edge that begins a two-pulse group (phase index zero). Lowering `en` inside a group lets both pulses of that group complete at full width, and then `clk_div` stays low.
- R7: While idle, an `en` high level that covers no rising edge of `clk_in` starts no pulse. When `en` is high at a rising edge while idle, a pulse starts on that edge.
- R8: Outside reset, no high or low interval of `clk_div` is shorter than one input half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable, sampled at the start of each two-pulse group |
| clk_div | output | 1 | Divided clock, input frequency / 2.5, 40% high |

## Verification
Steady running with enable held high is measured on every edge of the output. Each pulse is checked for its rise time, its width and the low gap before it. This separates a correct five-half-period cadence from a whole-cycle divider, and it shows whether the second pulse of a group really starts on a falling input edge. Lowering enable just after a group starts shows whether the group is cut short or finished. A brief enable level placed between two clock edges shows whether enable is sampled rather than used as a level. Asserting reset in the middle of a high phase, and releasing it again, tells an asynchronous clear apart from a synchronous one and pins down the latency from release to the first pulse.

// File: rtl/div_half_pkg.sv
package div_half_pkg;

  localparam int unsigned DEF_PERIOD_HALVES = 5;
  localparam int unsigned DEF_HIGH_HALVES   = 2;

  // Index (in rising-edge counts) of the falling edge that starts the second
  // pulse of a two-pulse group.
  function automatic int unsigned late_start(input int unsigned period_halves);
    return (period_halves - 1) / 2;
  endfunction

endpackage

// File: rtl/hdiv_rst_sync.sv
module hdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/hdiv_rise_phase.sv
module hdiv_rise_phase #(
  parameter int unsigned PERIOD_HALVES = div_half_pkg::DEF_PERIOD_HALVES,
  parameter int unsigned HIGH_HALVES   = div_half_pkg::DEF_HIGH_HALVES,
  localparam int unsigned W            = $clog2(PERIOD_HALVES)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] phase_o,
  output logic         pulse_o
);

  localparam int unsigned HALF_HI = HIGH_HALVES / 2;
  localparam logic [W-1:0] LAST   = W'(PERIOD_HALVES - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         pulse_q, pulse_d;
  logic         run;

  // Next state: enable only matters while the group counter rests at zero.
  always_comb begin
    run = en_i || (cnt_q != '0);
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
    pulse_d = run && (cnt_q < W'(HALF_HI));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign phase_o = cnt_q;
  assign pulse_o = pulse_q;

  // R1: the group counter closes after PERIOD_HALVES rising edges
  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));

  // R6 / R7: an idle counter with enable low stays idle and raises no pulse
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !en_i) |=> (cnt_q == '0 && !pulse_q));

endmodule

// File: rtl/hdiv_fall_phase.sv
module hdiv_fall_phase #(
  parameter int unsigned PERIOD_HALVES = div_half_pkg::DEF_PERIOD_HALVES,
  parameter int unsigned HIGH_HALVES   = div_half_pkg::DEF_HIGH_HALVES,
  localparam int unsigned W            = $clog2(PERIOD_HALVES)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] phase_i,
  output logic         pulse_o
);

  localparam int unsigned START   = div_half_pkg::late_start(PERIOD_HALVES);
  localparam int unsigned HALF_HI = HIGH_HALVES / 2;

  logic [W-1:0] mirror_q, mirror_d;
  logic         pulse_q, pulse_d;

  // The mirror lags the rising-edge counter by half a period; decoding the
  // mirror's current value places the pulse on the intended falling edge.
  always_comb begin
    mirror_d = phase_i;
    pulse_d  = (mirror_q >= W'(START)) && (mirror_q < W'(START + HALF_HI));
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mirror_q <= '0;
      pulse_q  <= 1'b0;
    end else begin
      mirror_q <= mirror_d;
      pulse_q  <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/hdiv_clk_gen.sv
module hdiv_clk_gen #(
  parameter int unsigned PERIOD_HALVES = div_half_pkg::DEF_PERIOD_HALVES,
  parameter int unsigned HIGH_HALVES   = div_half_pkg::DEF_HIGH_HALVES,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic en,
  output logic clk_div
);

  localparam int unsigned W = $clog2(PERIOD_HALVES);

  logic         rst_int_n;
  logic [W-1:0] phase_r;
  logic         pulse_r;
  logic         pulse_f;

  hdiv_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i   (clk_in),
    .arst_ni (rst_n),
    .rst_no  (rst_int_n)
  );

  hdiv_rise_phase #(
    .PERIOD_HALVES (PERIOD_HALVES),
    .HIGH_HALVES   (HIGH_HALVES)
  ) u_rise (
    .clk_i   (clk_in),
    .rst_ni  (rst_int_n),
    .en_i    (en),
    .phase_o (phase_r),
    .pulse_o (pulse_r)
  );

  hdiv_fall_phase #(
    .PERIOD_HALVES (PERIOD_HALVES),
    .HIGH_HALVES   (HIGH_HALVES)
  ) u_fall (
    .clk_i   (clk_in),
    .rst_ni  (rst_int_n),
    .phase_i (phase_r),
    .pulse_o (pulse_f)
  );

  // Two registered sources that never change on the same edge: hazard-free OR.
  assign clk_div = pulse_r | pulse_f;

  // R3: the two edge-domain pulses never overlap (seen from both edges)
  p_excl_rise_r3: assert property (@(posedge clk_in) disable iff (!rst_int_n)
    !(pulse_r && pulse_f));

  p_excl_fall_r3: assert property (@(negedge clk_in) disable iff (!rst_int_n)
    !(pulse_r && pulse_f));

  // R4: output is low whenever reset is asserted
  p_reset_low_r4: assert property (@(posedge clk_in)
    !rst_n |-> !clk_div);

endmodule

// File: tb/test_hdiv_clk_gen.sv
`timescale 1ns/1ps
module test_hdiv_clk_gen;

  localparam longint HALF   = 2;          // 250 MHz input clock
  localparam longint PER    = 2 * HALF;
  localparam longint WIDTH  = 2 * HALF;   // R2
  localparam longint GAP    = 5 * HALF;   // R1
  localparam longint GROUP  = 2 * GAP;

  logic clk_in = 1'b0;
  logic rst_n  = 1'b1;
  logic en     = 1'b0;
  logic clk_div;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  longint q_rise[$];
  longint q_width[$];

  hdiv_clk_gen i_hdiv_clk_gen (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .en      (en),
    .clk_div (clk_div)
  );

  always #(HALF) clk_in = ~clk_in;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic wait_until(input longint t);
    if (t > longint'($time)) #(t - longint'($time));
  endtask

  task automatic check_low(input string req);
    check(clk_div == 1'b0, req, longint'(clk_div), 0);
  endtask

  task automatic push_pulse(input longint r, input longint w);
    q_rise.push_back(r);
    q_width.push_back(w);
  endtask

  // Push C full groups starting at r0, then lower en just after the last
  // group has begun (R6) and wait past its end.
  task automatic run_groups(input longint r0, input int c);
    for (int g = 0; g < c; g++) begin
      push_pulse(r0 + g * GROUP, WIDTH);
      push_pulse(r0 + g * GROUP + GAP, WIDTH);
    end
    wait_until(r0 + (c - 1) * GROUP + 1);
    en = 1'b0;
    wait_until(r0 + c * GROUP + GROUP);
  endtask

  // Monitor: measures every pulse and compares with the scoreboard queue.
  initial begin
    longint tr, tf, last_f;
    bit have_f;
    have_f = 1'b0;
    last_f = 0;
    forever begin
      @(posedge clk_div);
      tr = longint'($time);
      if (have_f) check(tr - last_f >= HALF, "R8 low interval", tr - last_f, HALF);
      @(negedge clk_div);
      tf = longint'($time);
      if (q_rise.size() == 0) begin
        check(1'b0, "R6 unexpected pulse", tr, -1);
      end else begin
        longint er, ew;
        er = q_rise.pop_front();
        ew = q_width.pop_front();
        check(tr == er, "R1 R3 R5 rise time", tr, er);
        check(tf - tr == ew, "R2 high time", tf - tr, ew);
        if (ew >= HALF) check(tf - tr >= HALF, "R8 high interval", tf - tr, HALF);
      end
      have_f = 1'b1;
      last_f = tf;
    end
  end

  // Driver
  initial begin
    longint t_ref, r_tr;
    #1 rst_n = 1'b0;
    en = 1'b1;
    repeat (3) begin
      @(posedge clk_in); #1;
      check_low("R4 reset state");
    end

    // R5: release between edges; first pulse on third rising edge after.
    @(posedge clk_in); t_ref = longint'($time);
    #1 rst_n = 1'b1;
    run_groups(t_ref + 3 * PER, 3);
    check_low("R6 stopped after group");
    check(q_rise.size() == 0, "R6 groups completed", q_rise.size(), 0);

    // R7: enable high only between two rising edges starts nothing.
    @(posedge clk_in); #1 en = 1'b1;
    #(HALF) en = 1'b0;
    repeat (10) begin
      @(posedge clk_in); #1;
      check_low("R7 en between edges ignored");
    end

    // R7: enable high before a rising edge starts a pulse on that edge.
    @(posedge clk_in); t_ref = longint'($time);
    #1 en = 1'b1;
    for (int g = 0; g < 3; g++) begin
      push_pulse(t_ref + PER + g * GROUP, WIDTH);
      push_pulse(t_ref + PER + g * GROUP + GAP, WIDTH);
    end
    r_tr = t_ref + PER + 3 * GROUP;
    push_pulse(r_tr, 1);
    // R4: reset in the middle of a high phase clears the output at once.
    wait_until(r_tr + 1);
    rst_n = 1'b0;
    #0.1;
    check_low("R4 async clear");
    repeat (6) begin
      @(posedge clk_in); #1;
      check_low("R4 held in reset");
    end

    // R5 again after a mid-run reset: phase state restarted from zero.
    @(posedge clk_in); t_ref = longint'($time);
    #1 rst_n = 1'b1;
    run_groups(t_ref + 3 * PER, 2);
    check_low("R6 final stop");
    check(q_rise.size() == 0, "R1 all pulses seen", q_rise.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk_in);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule